// File: doc/BRIEF.md
# RMII Frame Transmitter with CRC-32

This block is the transmit half of a 100 Mb/s full-duplex Ethernet MAC facing a PHY over the reduced two-bit media interface. It runs on the 50 MHz reference clock and sends one dibit per clock. A client raises a request with a payload length. The block then pulls the payload one byte at a time from a byte-stream input. That payload holds the destination and source addresses and the type field. The block prefixes the preamble and start delimiter and appends the frame check sequence.

Lengths outside the legal range are corrected before the check sequence is computed. A short payload is padded with zero bytes up to the minimum, and those pad bytes enter the CRC. A long payload is cut at the maximum, and the surplus bytes are never pulled. After every frame the transmit enable stays low for a fixed inter-frame gap of 50 clocks, which is 1 µs or 100 bit times. A request that is already waiting starts on the first cycle the gap allows.

The busy output is the completion handshake. It rises when a request is taken and falls on the same edge as the transmit enable, so the client holds its request until busy is seen and treats the fall of busy as "frame sent".

Top module: `rmii_tx_mac`

## Requirements
- R1: Each clock with `tx_en_o` high carries one dibit. `txd_o[0]` is the even-numbered bit and `txd_o[1]` the odd-numbered bit of the current byte, and bit pair 1:0 goes out first.
- R2: A frame begins with seven bytes of 0x55 followed by one byte of 0xD5.
- R3: Payload bytes go out in the order they are pulled. `pull_o` is high in the clock whose rising edge consumes `data_i`, and exactly min(length, 1518) bytes are pulled per frame.
- R4: A length below 60 is padded with 0x00 bytes up to 60 payload bytes, and the pad bytes are covered by the CRC.
- R5: A length above 1518 is clamped to 1518 payload bytes, and no byte beyond the 1518th is pulled.
- R6: The four bytes after the payload are the bitwise inverse of a CRC-32 with reflected polynomial 0xEDB88320 and initial value 0xFFFFFFFF, least significant byte first. Running the same CRC over payload plus these four bytes leaves 0xDEBB20E3.
- R7: `tx_en_o` is high for exactly 4 × (8 + clamped length + 4) consecutive clocks per frame.
- R8: `txd_o` is 00 in every clock in which `tx_en_o` is low.
- R9: Between two frames `tx_en_o` stays low for at least 50 clocks. A request held during the gap starts a frame whose `tx_en_o` rises after exactly 50 low clocks.
- R10: From idle, a request seen at a rising edge sets `busy_o` after that edge and `tx_en_o` one clock later. `busy_o` falls on the same edge as `tx_en_o`.
- R11: While reset is asserted, `tx_en_o`, `txd_o`, `busy_o` and `pull_o` are all low, and an interrupted frame is abandoned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Transmit request, held until `busy_o` rises |
| len_i | input | LEN_W | Payload length in bytes (without CRC), sampled on acceptance |
| data_i | input | 8 | Current payload byte, consumed when `pull_o` is high |
| pull_o | output | 1 | Byte consume strobe for `data_i` |
| busy_o | output | 1 | Frame in progress; its fall marks completion |
| txd_o | output | 2 | Transmit dibit to the PHY |
| tx_en_o | output | 1 | Transmit enable to the PHY |

## Verification
From idle, `busy_o` is due one clock after the edge that sees the request, and `tx_en_o` one clock after that. The bench probes those two clocks at the falling edge after each. The wire image is rebuilt by a monitor that samples `txd_o` and `tx_en_o` on every falling edge. Frame length, byte contents and the gap are therefore counted in whole clocks, away from the edge where the outputs change. Completion is detected as the falling-edge sample where `busy_o` is first low. At that sample `tx_en_o` must also have just dropped, and the pull count and captured bytes are compared with values the bench computes itself from length and seed.

// File: rtl/rmii_tx_pkg.sv
package rmii_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_DATA = 3'd2,
    ST_FCS  = 3'd3,
    ST_GAP  = 3'd4
  } tx_state_e;

  // Reflected CRC-32 advanced by one byte, least significant bit first.
  function automatic logic [31:0] crc32_step(input logic [31:0] crc_in,
                                             input logic [7:0]  data,
                                             input logic [31:0] poly);
    logic [31:0] c;
    logic        fb;
    c = crc_in;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ data[i];
      c  = {1'b0, c[31:1]};
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction

endpackage

// File: rtl/rmii_len_clamp.sv
module rmii_len_clamp #(
  parameter int LEN_W   = 11,
  parameter int MIN_LEN = 60,
  parameter int MAX_LEN = 1518
) (
  input  logic [LEN_W-1:0] len_i,
  output logic [LEN_W-1:0] len_o
);

  localparam logic [LEN_W-1:0] LO = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] HI = LEN_W'(MAX_LEN);

  always_comb begin
    if (len_i < LO)      len_o = LO;
    else if (len_i > HI) len_o = HI;
    else                 len_o = len_i;
  end

endmodule

// File: rtl/rmii_crc32.sv
module rmii_crc32
  import rmii_tx_pkg::*;
#(
  parameter logic [31:0] POLY = 32'hEDB88320
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init_i,
  input  logic       upd_i,
  input  logic       shift_i,
  input  logic [7:0] byte_i,
  output logic [7:0] fcs_byte_o
);

  logic [31:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (init_i)       crc_d = 32'hFFFF_FFFF;
    else if (upd_i)   crc_d = crc32_step(crc_q, byte_i, POLY);
    else if (shift_i) crc_d = {8'h00, crc_q[31:8]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= 32'hFFFF_FFFF;
    else if (init_i || upd_i || shift_i) crc_q <= crc_d;
  end

  assign fcs_byte_o = ~crc_q[7:0];

  // R6: the register is only ever advanced by one operation per clock
  assert_single_op_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({init_i, upd_i, shift_i}) <= 1);

endmodule

// File: rtl/rmii_gap_timer.sv
module rmii_gap_timer #(
  parameter int GAP_CLKS = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic run_i,
  output logic done_o
);

  localparam int GW = $clog2(GAP_CLKS + 1);

  logic [GW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)                           cnt_d = GW'(GAP_CLKS);
    else if (run_i && cnt_q > GW'(1))     cnt_d = cnt_q - GW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (load_i || run_i) cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q <= GW'(1));

  // R9: a freshly loaded gap is never reported as finished in the next clock
  assert_gap_not_short_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !done_o);

endmodule

// File: rtl/rmii_tx_mac.sv
module rmii_tx_mac
  import rmii_tx_pkg::*;
#(
  parameter int LEN_W     = 11,
  parameter int MIN_LEN   = 60,
  parameter int MAX_LEN   = 1518,
  parameter int PRE_BYTES = 7,
  parameter int GAP_CLKS  = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [7:0]       data_i,
  output logic             pull_o,
  output logic             busy_o,
  output logic [1:0]       txd_o,
  output logic             tx_en_o
);

  localparam int FCS_BYTES = 4;
  localparam int MIN_CYC   = 4 * (PRE_BYTES + 1 + MIN_LEN + FCS_BYTES);
  localparam int MAX_CYC   = 4 * (PRE_BYTES + 1 + MAX_LEN + FCS_BYTES);
  localparam int EN_W      = $clog2(MAX_CYC + 2);
  localparam int LOW_W     = $clog2(GAP_CLKS + 1);

  tx_state_e        state_q, state_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [1:0]       dib_q, dib_d;
  logic [7:0]       sh_q, sh_d;
  logic [LEN_W-1:0] raw_q, raw_d;
  logic [LEN_W-1:0] cl_q, cl_d;
  logic             busy_q, busy_d;
  logic [1:0]       txd_q, txd_d;
  logic             tx_en_q, tx_en_d;

  logic [LEN_W-1:0] len_cl;
  logic [LEN_W-1:0] pay_idx;
  logic             pay_has;
  logic [7:0]       pay_byte;
  logic [7:0]       fcs_byte;
  logic             last_dib;
  logic             start;
  logic             pull;
  logic             crc_init, crc_upd, crc_shift;
  logic             gap_load, gap_done;

  rmii_len_clamp #(
    .LEN_W  (LEN_W),
    .MIN_LEN(MIN_LEN),
    .MAX_LEN(MAX_LEN)
  ) u_clamp (
    .len_i(len_i),
    .len_o(len_cl)
  );

  rmii_crc32 #(
    .POLY(32'hEDB88320)
  ) u_crc (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_i    (crc_init),
    .upd_i     (crc_upd),
    .shift_i   (crc_shift),
    .byte_i    (pay_byte),
    .fcs_byte_o(fcs_byte)
  );

  rmii_gap_timer #(
    .GAP_CLKS(GAP_CLKS)
  ) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(gap_load),
    .run_i (state_q == ST_GAP),
    .done_o(gap_done)
  );

  assign last_dib = (dib_q == 2'd3);
  assign pay_idx  = (state_q == ST_PRE) ? '0 : cnt_q + LEN_W'(1);
  assign pay_has  = (pay_idx < raw_q);
  assign pay_byte = pay_has ? data_i : 8'h00;

  // next-state logic
  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    dib_d     = dib_q + 2'd1;
    sh_d      = {2'b00, sh_q[7:2]};
    raw_d     = raw_q;
    cl_d      = cl_q;
    busy_d    = busy_q;
    start     = 1'b0;
    pull      = 1'b0;
    crc_init  = 1'b0;
    crc_upd   = 1'b0;
    crc_shift = 1'b0;
    gap_load  = 1'b0;

    case (state_q)
      ST_IDLE: begin
        dib_d = '0;
        start = req_i;
      end
      ST_GAP: begin
        dib_d  = '0;
        busy_d = 1'b0;
        if (gap_done) begin
          start = req_i;
          if (!req_i) state_d = ST_IDLE;
        end
      end
      ST_PRE: begin
        if (last_dib) begin
          cnt_d = cnt_q + LEN_W'(1);
          if (cnt_q == LEN_W'(PRE_BYTES - 1)) begin
            sh_d = 8'hD5;
          end else if (cnt_q == LEN_W'(PRE_BYTES)) begin
            state_d = ST_DATA;
            cnt_d   = '0;
            sh_d    = pay_byte;
            pull    = pay_has;
            crc_upd = 1'b1;
          end else begin
            sh_d = 8'h55;
          end
        end
      end
      ST_DATA: begin
        if (last_dib) begin
          if (cnt_q == cl_q - LEN_W'(1)) begin
            state_d   = ST_FCS;
            cnt_d     = '0;
            sh_d      = fcs_byte;
            crc_shift = 1'b1;
          end else begin
            cnt_d   = cnt_q + LEN_W'(1);
            sh_d    = pay_byte;
            pull    = pay_has;
            crc_upd = 1'b1;
          end
        end
      end
      ST_FCS: begin
        if (last_dib) begin
          if (cnt_q == LEN_W'(FCS_BYTES - 1)) begin
            state_d  = ST_GAP;
            gap_load = 1'b1;
          end else begin
            cnt_d     = cnt_q + LEN_W'(1);
            sh_d      = fcs_byte;
            crc_shift = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (start) begin
      state_d  = ST_PRE;
      cnt_d    = '0;
      dib_d    = '0;
      sh_d     = 8'h55;
      raw_d    = len_i;
      cl_d     = len_cl;
      busy_d   = 1'b1;
      crc_init = 1'b1;
    end

    tx_en_d = (state_q == ST_PRE) || (state_q == ST_DATA) || (state_q == ST_FCS);
    txd_d   = tx_en_d ? sh_q[1:0] : 2'b00;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      dib_q   <= '0;
      sh_q    <= '0;
      raw_q   <= '0;
      cl_q    <= '0;
      busy_q  <= 1'b0;
      txd_q   <= 2'b00;
      tx_en_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      dib_q   <= dib_d;
      sh_q    <= sh_d;
      if (start) begin
        raw_q <= raw_d;
        cl_q  <= cl_d;
      end
      busy_q  <= busy_d;
      txd_q   <= txd_d;
      tx_en_q <= tx_en_d;
    end
  end

  assign pull_o  = pull;
  assign busy_o  = busy_q;
  assign txd_o   = txd_q;
  assign tx_en_o = tx_en_q;

  // checker counters for the output timing assertions
  logic [EN_W-1:0]  en_run_q;
  logic [LOW_W-1:0] low_run_q;
  logic             seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_run_q  <= '0;
      low_run_q <= '0;
      seen_q    <= 1'b0;
    end else begin
      en_run_q <= tx_en_q ? en_run_q + EN_W'(1) : '0;
      if (tx_en_q)                      low_run_q <= '0;
      else if (low_run_q != LOW_W'(GAP_CLKS)) low_run_q <= low_run_q + LOW_W'(1);
      if (tx_en_q) seen_q <= 1'b1;
    end
  end

  assert_txd_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en_o |-> (txd_o == 2'b00));

  assert_busy_ends_with_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $fell(tx_en_o));

  assert_gap_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_en_o) && seen_q) |-> (low_run_q == LOW_W'(GAP_CLKS)));

  assert_frame_span_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_en_o) |-> (en_run_q[1:0] == 2'b00 && en_run_q >= EN_W'(MIN_CYC)
                        && en_run_q <= EN_W'(MAX_CYC)));

  assert_pull_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pull_o |-> busy_o);

endmodule

// File: tb/sim_rmii_tx_mac.sv
`timescale 1ns/1ps
module sim_rmii_tx_mac;

  localparam int LEN_W = 11;
  localparam int NV    = 11;
  // {length, seed}
  localparam logic [18:0] VEC [0:NV-1] = '{
    {11'd60,   8'h11},
    {11'd0,    8'h22},
    {11'd1,    8'h33},
    {11'd59,   8'h44},
    {11'd61,   8'h55},
    {11'd64,   8'h66},
    {11'd100,  8'h77},
    {11'd777,  8'h88},
    {11'd1518, 8'h99},
    {11'd1519, 8'hAA},
    {11'd2000, 8'hBB}
  };

  logic             clk;
  logic             rst_n;
  logic             req_i;
  logic [LEN_W-1:0] len_i;
  logic [7:0]       data_i;
  logic             pull_o;
  logic             busy_o;
  logic [1:0]       txd_o;
  logic             tx_en_o;

  int   total, failed;
  bit   finished;
  int   pulls, base;
  logic [7:0] cur_seed;

  logic [7:0] rx [0:1599];
  int   rx_n, dcnt, en_cyc, low_run, last_gap, txd_bad;
  bit   prev_en;
  logic [7:0] cur;

  rmii_tx_mac u0 (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (req_i),
    .len_i  (len_i),
    .data_i (data_i),
    .pull_o (pull_o),
    .busy_o (busy_o),
    .txd_o  (txd_o),
    .tx_en_o(tx_en_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] gen(input logic [7:0] s, input int k);
    return 8'(int'(s) + k * 29 + (k >> 3));
  endfunction

  function automatic logic [31:0] crc_b(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 32'hEDB88320;
      else             r = r >> 1;
    end
    return r;
  endfunction

  assign data_i = gen(cur_seed, pulls - base);

  always @(posedge clk) begin
    if (rst_n && pull_o) pulls <= pulls + 1;
  end

  // wire monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_en = 1'b0;
      low_run = 0;
    end else begin
      if (tx_en_o) begin
        if (!prev_en) begin
          rx_n = 0; dcnt = 0; en_cyc = 0; last_gap = low_run;
        end
        cur = {txd_o, cur[7:2]};
        dcnt++;
        en_cyc++;
        if (dcnt % 4 == 0 && rx_n < 1600) begin
          rx[rx_n] = cur;
          rx_n++;
        end
      end else begin
        if (txd_o != 2'b00) txd_bad++;
        if (prev_en) low_run = 1; else low_run++;
      end
      prev_en = tx_en_o;
    end
  end

  task automatic tick();
    @(negedge clk);
    #2;
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_frame(input int L, input logic [7:0] s);
    int C, tot, pre_err, pay_err, fcs_err, k;
    logic [31:0] c, res;
    logic [7:0] b, fcsb;
    string ptag;
    C   = (L < 60) ? 60 : (L > 1518) ? 1518 : L;
    tot = 8 + C + 4;
    ptag = (L < 60) ? "R4" : (L > 1518) ? "R5" : "R3";
    chk(rx_n == tot, "R7", "byte count", rx_n, tot);
    chk(en_cyc == 4 * tot, "R7", "tx_en cycles", en_cyc, 4 * tot);
    pre_err = 0;
    for (int i = 0; i < 8 && i < rx_n; i++) begin
      b = (i == 7) ? 8'hD5 : 8'h55;
      if (rx[i] != b) pre_err++;
    end
    chk(pre_err == 0, "R2", "preamble/SFD mismatches (R1 dibit order)", pre_err, 0);
    pay_err = 0;
    c = 32'hFFFF_FFFF;
    for (int p = 0; p < C; p++) begin
      b = (p < L) ? gen(s, p) : 8'h00;
      c = crc_b(c, b);
      if (8 + p < rx_n && rx[8 + p] != b) pay_err++;
    end
    chk(pay_err == 0, ptag, "payload mismatches", pay_err, 0);
    fcs_err = 0;
    c = ~c;
    for (int j = 0; j < 4; j++) begin
      fcsb = c[8*j +: 8];
      k = 8 + C + j;
      if (k >= rx_n || rx[k] != fcsb) fcs_err++;
    end
    chk(fcs_err == 0, "R6", "FCS byte mismatches", fcs_err, 0);
    res = 32'hFFFF_FFFF;
    for (int i = 8; i < rx_n; i++) res = crc_b(res, rx[i]);
    chk(res == 32'hDEBB20E3, "R6", "CRC residue", res, 32'hDEBB20E3);
    chk(pulls - base == ((L > 1518) ? 1518 : L), (L > 1518) ? "R5" : "R3",
        "bytes pulled", pulls - base, (L > 1518) ? 1518 : L);
  endtask

  task automatic wait_done();
    bit en_before;
    do begin
      en_before = tx_en_o;
      tick();
    end while (busy_o);
    chk(en_before && !tx_en_o, "R10", "busy fall with tx_en fall", {31'd0, tx_en_o}, 0);
  endtask

  task automatic run_frame(input int L, input logic [7:0] s, input bit chk_gap);
    cur_seed = s;
    len_i    = LEN_W'(L);
    base     = pulls;
    req_i    = 1'b1;
    while (!busy_o) tick();
    req_i = 1'b0;
    wait_done();
    check_frame(L, s);
    if (chk_gap) chk(last_gap == 50, "R9", "gap clocks before frame", last_gap, 50);
  endtask

  initial begin
    total = 0; failed = 0; finished = 0;
    pulls = 0; base = 0; cur_seed = 8'h00;
    rx_n = 0; dcnt = 0; en_cyc = 0; low_run = 0; last_gap = 0; txd_bad = 0;
    prev_en = 0; cur = 8'h00;
    rst_n = 1'b0; req_i = 1'b0; len_i = '0;
    repeat (3) tick();
    chk(!tx_en_o && txd_o == 2'b00 && !busy_o && !pull_o, "R11", "outputs in reset",
        {28'd0, tx_en_o, txd_o, busy_o}, 0);
    rst_n = 1'b1;
    repeat (2) tick();

    // R10: acceptance latency from idle
    cur_seed = 8'h5A; len_i = LEN_W'(60); base = pulls;
    req_i = 1'b1;
    tick();
    chk(busy_o && !tx_en_o, "R10", "busy one clock after request", {30'd0, busy_o, tx_en_o}, 2);
    req_i = 1'b0;
    tick();
    chk(tx_en_o, "R10", "tx_en one clock after busy", {31'd0, tx_en_o}, 1);
    wait_done();
    check_frame(60, 8'h5A);

    // table of lengths, back to back so each waits out the gap
    for (int i = 0; i < NV; i++) begin
      run_frame(int'(VEC[i][18:8]), VEC[i][7:0], 1'b1);
    end

    // R11: reset in the middle of a frame, then a clean frame
    cur_seed = 8'hC3; len_i = LEN_W'(100); base = pulls;
    req_i = 1'b1;
    repeat (40) tick();
    req_i = 1'b0;
    rst_n = 1'b0;
    tick();
    chk(!tx_en_o && txd_o == 2'b00 && !busy_o && !pull_o, "R11", "outputs after mid-frame reset",
        {28'd0, tx_en_o, txd_o, busy_o}, 0);
    rst_n = 1'b1;
    repeat (3) tick();
    chk(!tx_en_o && !busy_o, "R11", "abandoned frame stays idle", {30'd0, tx_en_o, busy_o}, 0);
    run_frame(75, 8'h3C, 1'b0);

    chk(txd_bad == 0, "R8", "txd nonzero while tx_en low", txd_bad, 0);

    finished = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      failed++;
      $display("FAIL R7 watchdog actual=hung expected=frame completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

endmodule